// File: doc/BRIEF.md
# Triple Watchdog Timer Peripheral

This peripheral holds three watchdog timers that count down independently behind a small register bus. Each timer has a 16-bit downcounter, a limit register and a status byte. A prescaler divides the system clock into one tick per tenth of a second, and a running timer loses one count on each tick. Software arms a timer by writing its limit. It services the timer by reading the downcounter, and that read reloads the count from the limit.

Each timer has its own expiry action. Timer 0 holds an interrupt line high. Timer 1 sends a fixed-length pulse on a CPU reset output. Timer 2 sends the same kind of pulse on a board-wide reset output. A shared mask register can block any of these actions without stopping the count. Halfword registers travel on the bus with their two bytes exchanged. Byte-wide registers use data lane [7:0].

Top module: `wdt_trio`

## Requirements
- R1: Reset state. Every downcounter and every limit register holds 1, so a read returns 0x0100 on the bus. Every status byte reads 0. The mask reads 0x0007. All three action outputs are low.
- R2: Writing a timer's limit register (window offset 0x4) loads both the limit and the downcounter with the written value, sets the running flag and clears the expired flag. Halfword data is byte-swapped: bus bits [15:8] carry value bits [7:0], and bus bits [7:0] carry value bits [15:8].
- R3: Ticks occur on rising edge TICK_DIV after reset release and then every TICK_DIV edges. A running timer's count drops by one on each tick. A timer that is not running keeps its count.
- R4: When a tick takes a running timer's count to zero, the count holds at 0, the running flag clears and the expired flag sets. The expired flag stays set until the limit register is next written.
- R5: A read of the downcounter (window offset 0x0) returns the current count, byte-swapped, and on the same edge reloads the count from the limit. A read of the limit register returns the limit and has no side effect.
- R6: The status byte (window offset 0x8) reads on lane [7:0]. Bit 0 is running and bit 1 is expired. Every other bit of rdData reads 0.
- R7: The mask register sits at 0x30. Bit i set to 1 blocks the expiry action of timer i. Unused bits read 0. A masked timer still counts, expires and reports its status.
- R8: irqOut is high exactly while timer 0 is expired and mask bit 0 is clear. It follows later writes to the mask.
- R9: When timer 1 expires with mask bit 1 clear, cpuRstOut goes high after the expiry edge and stays high for PULSE_LEN cycles. boardRstOut does the same for timer 2 and mask bit 2. An expiry while the mask bit is set produces no pulse.
- R10: Timer windows start at 0x00, 0x10 and 0x20. Address 0x34 is a read-only summary whose bit i is timer i's expired flag. Writes to 0x34, to status bytes and to unmapped offsets have no effect. Unmapped reads return 0.
- R11: The three timers are independent. Bus accesses and expiry of one timer leave the state of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus access strobe, one cycle per access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 6 | Byte address of the register |
| wrData | input | 16 | Write data (halfwords byte-swapped, bytes on [7:0]) |
| rdData | output | 16 | Read data, valid in the cycle of the strobe |
| irqOut | output | 1 | Level interrupt from timer 0 |
| cpuRstOut | output | 1 | CPU reset pulse from timer 1 |
| boardRstOut | output | 1 | Board reset pulse from timer 2 |

## Verification
Three checks depend on landing a bus access on an exact edge relative to the free-running tick: the reload-on-read, the exact expiry edge and the start of the reset pulse. The bench counts rising edges from reset release and waits for a tick edge before it arms a timer. Every later access and sample is then placed a known number of edges after that point. The masked-expiry case is set up on purpose: a timer expires while its mask bit is set, which should give no pulse, and the bench then shows that its status still reports the expiry.

// File: rtl/wdt_trio_pkg.sv
package wdt_trio_pkg;
  localparam int NUM_TIMERS = 3;
  localparam int HALF_W     = 16;
  localparam int ADDR_W     = 6;

  // Window and offset decode: the window index sits in address bits [5:4].
  localparam logic [1:0] WIN_PLD  = 2'd3;
  localparam logic [3:0] OFF_CNT  = 4'h0;
  localparam logic [3:0] OFF_LIM  = 4'h4;
  localparam logic [3:0] OFF_STAT = 4'h8;
  localparam logic [3:0] OFF_MASK = 4'h0;
  localparam logic [3:0] OFF_SUM  = 4'h4;

  // Bit i set: timer i drives a level action; clear: a timed pulse.
  localparam logic [NUM_TIMERS-1:0] ACT_LEVEL = 3'b001;

  typedef logic [HALF_W-1:0] half_t;

  typedef struct packed {
    logic [NUM_TIMERS-1:0] limitWr;
    logic [NUM_TIMERS-1:0] cntRd;
    logic                  maskWr;
    half_t                 wrHalf;
    logic [NUM_TIMERS-1:0] maskVal;
  } wdt_stb_t;

  function automatic half_t laneSwap(half_t v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/wdt_trio_ctrl.sv
module wdt_trio_ctrl
  import wdt_trio_pkg::*;
(
  input  logic                         reqValid,
  input  logic                         reqWrite,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  half_t                        wrData,
  input  half_t [NUM_TIMERS-1:0]       cntQ,
  input  half_t [NUM_TIMERS-1:0]       limQ,
  input  logic  [NUM_TIMERS-1:0]       runQ,
  input  logic  [NUM_TIMERS-1:0]       expQ,
  input  logic  [NUM_TIMERS-1:0]       maskQ,
  output wdt_stb_t                     stb,
  output half_t                        rdData
);
  logic [1:0] win;
  logic [3:0] off;
  logic       rdEn;
  logic       wrEn;

  assign win  = reqAddr[5:4];
  assign off  = reqAddr[3:0];
  assign rdEn = reqValid & ~reqWrite;
  assign wrEn = reqValid & reqWrite;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_dec
    assign stb.limitWr[i] = wrEn && (win == 2'(i)) && (off == OFF_LIM);
    assign stb.cntRd[i]   = rdEn && (win == 2'(i)) && (off == OFF_CNT);
  end

  assign stb.maskWr  = wrEn && (win == WIN_PLD) && (off == OFF_MASK);
  assign stb.wrHalf  = laneSwap(wrData);
  assign stb.maskVal = wrData[NUM_TIMERS-1:0];

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      if (win == WIN_PLD) begin
        case (off)
          OFF_MASK: rdData[NUM_TIMERS-1:0] = maskQ;
          OFF_SUM:  rdData[NUM_TIMERS-1:0] = expQ;
          default:  rdData = '0;
        endcase
      end else if (int'(win) < NUM_TIMERS) begin
        case (off)
          OFF_CNT:  rdData = laneSwap(cntQ[win]);
          OFF_LIM:  rdData = laneSwap(limQ[win]);
          OFF_STAT: rdData[1:0] = {expQ[win], runQ[win]};
          default:  rdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wdt_trio_dp.sv
module wdt_trio_dp
  import wdt_trio_pkg::*;
#(
  parameter int TICK_DIV  = 5000000,
  parameter int PULSE_LEN = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  wdt_stb_t               stb,
  output half_t [NUM_TIMERS-1:0] cntQ,
  output half_t [NUM_TIMERS-1:0] limQ,
  output logic  [NUM_TIMERS-1:0] runQ,
  output logic  [NUM_TIMERS-1:0] expQ,
  output logic  [NUM_TIMERS-1:0] maskQ,
  output logic  [NUM_TIMERS-1:0] actOut
);
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int PULSE_W = $clog2(PULSE_LEN + 1);

  logic [PRE_W-1:0]      preQ;
  logic                  tick;
  logic [NUM_TIMERS-1:0] expireEv;

  assign tick = (preQ == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN)     preQ <= '0;
    else if (tick) preQ <= '0;
    else           preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           maskQ <= '1;
    else if (stb.maskWr) maskQ <= stb.maskVal;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
    assign expireEv[i] = !stb.limitWr[i] && !stb.cntRd[i] && tick &&
                         runQ[i] && (cntQ[i] <= half_t'(1));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ[i] <= half_t'(1);
        limQ[i] <= half_t'(1);
        runQ[i] <= 1'b0;
        expQ[i] <= 1'b0;
      end else if (stb.limitWr[i]) begin
        cntQ[i] <= stb.wrHalf;
        limQ[i] <= stb.wrHalf;
        runQ[i] <= 1'b1;
        expQ[i] <= 1'b0;
      end else if (stb.cntRd[i]) begin
        cntQ[i] <= limQ[i];
      end else if (expireEv[i]) begin
        cntQ[i] <= '0;
        runQ[i] <= 1'b0;
        expQ[i] <= 1'b1;
      end else if (tick && runQ[i]) begin
        cntQ[i] <= cntQ[i] - 1'b1;
      end
    end

    if (ACT_LEVEL[i]) begin : g_level
      assign actOut[i] = expQ[i] & ~maskQ[i];
    end else begin : g_pulse
      logic [PULSE_W-1:0] pulseQ;
      always_ff @(posedge clk) begin
        if (!rstN)                       pulseQ <= '0;
        else if (expireEv[i] && !maskQ[i]) pulseQ <= PULSE_W'(PULSE_LEN);
        else if (pulseQ != '0)           pulseQ <= pulseQ - 1'b1;
      end
      assign actOut[i] = (pulseQ != '0);
    end
  end
endmodule

// File: rtl/wdt_trio.sv
module wdt_trio
  import wdt_trio_pkg::*;
#(
  parameter int TICK_DIV  = 5000000,
  parameter int PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [5:0]  reqAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        irqOut,
  output logic        cpuRstOut,
  output logic        boardRstOut
);
  wdt_stb_t              stb;
  half_t [NUM_TIMERS-1:0] cntQ;
  half_t [NUM_TIMERS-1:0] limQ;
  logic  [NUM_TIMERS-1:0] runQ;
  logic  [NUM_TIMERS-1:0] expQ;
  logic  [NUM_TIMERS-1:0] maskQ;
  logic  [NUM_TIMERS-1:0] actOut;

  wdt_trio_ctrl ctrl_i (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .wrData   (wrData),
    .cntQ     (cntQ),
    .limQ     (limQ),
    .runQ     (runQ),
    .expQ     (expQ),
    .maskQ    (maskQ),
    .stb      (stb),
    .rdData   (rdData)
  );

  wdt_trio_dp #(
    .TICK_DIV  (TICK_DIV),
    .PULSE_LEN (PULSE_LEN)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cntQ   (cntQ),
    .limQ   (limQ),
    .runQ   (runQ),
    .expQ   (expQ),
    .maskQ  (maskQ),
    .actOut (actOut)
  );

  assign irqOut      = actOut[0];
  assign cpuRstOut   = actOut[1];
  assign boardRstOut = actOut[2];
endmodule

// File: rtl/wdt_trio_chk.sv
module wdt_trio_chk
  import wdt_trio_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   reqValid,
  input logic                   reqWrite,
  input logic [5:0]             reqAddr,
  input logic [15:0]            rdData,
  input logic                   irqOut,
  input logic                   cpuRstOut,
  input logic                   boardRstOut,
  input wdt_stb_t               stb,
  input half_t [NUM_TIMERS-1:0] cntQ,
  input logic  [NUM_TIMERS-1:0] expQ,
  input logic  [NUM_TIMERS-1:0] maskQ
);
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_t
    // R3: without a reload the count never rises
    assert_no_count_up_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!stb.limitWr[i] && !stb.cntRd[i]) |=> (cntQ[i] <= $past(cntQ[i])));
    // R4: entering expiry leaves the count at zero
    assert_expire_at_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(expQ[i]) |-> (cntQ[i] == '0));
    // R4: expired is sticky until a limit write
    assert_expired_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
      (expQ[i] && !stb.limitWr[i]) |=> expQ[i]);
  end

  // R8: interrupt only from an unmasked expired timer 0
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (expQ[0] && !maskQ[0]));

  // R9: CPU reset pulse starts with an unmasked expiry of timer 1
  assert_cpu_pulse_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRstOut) |-> ($rose(expQ[1]) && !$past(maskQ[1])));

  // R9: board reset pulse starts with an unmasked expiry of timer 2
  assert_board_pulse_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(boardRstOut) |-> ($rose(expQ[2]) && !$past(maskQ[2])));

  // R6: status reads carry only two meaningful bits
  assert_status_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && (reqAddr[5:4] != 2'd3) && (reqAddr[3:0] == 4'h8))
      |-> (rdData[15:2] == '0));
endmodule

bind wdt_trio wdt_trio_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .rdData      (rdData),
  .irqOut      (irqOut),
  .cpuRstOut   (cpuRstOut),
  .boardRstOut (boardRstOut),
  .stb         (stb),
  .cntQ        (cntQ),
  .expQ        (expQ),
  .maskQ       (maskQ)
);

// File: tb/wdt_trio_tb_top.sv
`timescale 1ns/1ps
module wdt_trio_tb_top;
  localparam int DIV   = 10;
  localparam int PLEN  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut, cpuRstOut, boardRstOut;

  int checks = 0;
  int failures = 0;
  int e = 0;

  always #10 clk = ~clk;
  always @(posedge clk) if (rstN) e <= e + 1;

  wdt_trio #(.TICK_DIV(DIV), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut), .cpuRstOut(cpuRstOut), .boardRstOut(boardRstOut));

  function automatic logic [15:0] sw(logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%04h expected=0x%04h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = a;
    #1 d = rdData;
    @(posedge clk);
    #5 reqValid = 1'b0;
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = a; wrData = d;
    @(posedge clk);
    #5 reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic align(output int n);
    idle(1);
    while (e % DIV != 0) idle(1);
    n = e;
  endtask

  task automatic waitBefore(input int t);
    while (e < t - 1) idle(1);
  endtask

  task automatic testReset();
    logic [15:0] d;
    check("R1 irq", 16'(irqOut), 16'h0);
    check("R1 cpuRst", 16'(cpuRstOut), 16'h0);
    check("R1 boardRst", 16'(boardRstOut), 16'h0);
    busRead(6'h00, d); check("R1 cnt0", d, 16'h0100);
    busRead(6'h14, d); check("R1 lim1", d, 16'h0100);
    busRead(6'h28, d); check("R1 stat2", d, 16'h0000);
    busRead(6'h30, d); check("R1 mask", d, 16'h0007);
  endtask

  task automatic testIdleHold();
    logic [15:0] d;
    idle(3 * DIV);
    busRead(6'h10, d); check("R3 idle cnt1 holds", d, 16'h0100);
    busRead(6'h18, d); check("R3 idle stat1", d, 16'h0000);
  endtask

  task automatic testCountReload();
    logic [15:0] d;
    int n;
    busWrite(6'h24, sw(16'h1234));
    busRead(6'h24, d); check("R2 swapped limit2", d, 16'h3412);
    busRead(6'h28, d); check("R2 running stat2", d, 16'h0001);
    align(n);
    busWrite(6'h04, sw(16'd5));
    waitBefore(n + 21);
    busRead(6'h00, d); check("R3 R5 cnt0 after 2 ticks", d, sw(16'd3));
    busRead(6'h04, d); check("R5 lim0 read", d, sw(16'd5));
    busRead(6'h00, d); check("R5 cnt0 reloaded", d, sw(16'd5));
    waitBefore(n + 31);
    busRead(6'h00, d); check("R3 cnt0 one tick after reload", d, sw(16'd4));
  endtask

  task automatic testExpire();
    logic [15:0] d;
    int n;
    align(n);
    busWrite(6'h04, sw(16'd2));
    waitBefore(n + 20);
    busRead(6'h08, d); check("R4 R6 running before expiry", d, 16'h0001);
    check("R8 masked no irq", 16'(irqOut), 16'h0);
    busRead(6'h08, d); check("R4 R6 expired", d, 16'h0002);
    busRead(6'h00, d); check("R4 cnt holds zero", d, 16'h0000);
    idle(3 * DIV);
    busRead(6'h08, d); check("R4 expired sticky", d, 16'h0002);
  endtask

  task automatic testIrq();
    logic [15:0] d;
    busWrite(6'h30, 16'h0006);
    check("R8 irq on unmask", 16'(irqOut), 16'h1);
    busRead(6'h30, d); check("R7 mask readback", d, 16'h0006);
    busWrite(6'h30, 16'h00FF);
    check("R8 irq off on mask", 16'(irqOut), 16'h0);
    busRead(6'h30, d); check("R7 upper mask bits zero", d, 16'h0007);
    busWrite(6'h30, 16'h0006);
    check("R8 irq back on", 16'(irqOut), 16'h1);
    busWrite(6'h04, sw(16'h0050));
    check("R2 R8 limit write clears irq", 16'(irqOut), 16'h0);
    busRead(6'h08, d); check("R2 expired cleared", d, 16'h0001);
  endtask

  task automatic testCpuRst();
    logic [15:0] d;
    int n;
    int seen = 0;
    align(n);
    busWrite(6'h14, sw(16'd1));
    waitBefore(n + 10);
    for (int k = 0; k < PLEN + 2; k++) begin
      idle(1);
      if (cpuRstOut) seen++;
    end
    check("R9 R7 masked expiry no pulse", 16'(seen), 16'h0);
    busRead(6'h18, d); check("R7 masked timer1 expired", d, 16'h0002);
    busWrite(6'h30, 16'h0004);
    align(n);
    busWrite(6'h14, sw(16'd1));
    waitBefore(n + 10);
    idle(1);
    check("R9 cpuRst rises", 16'(cpuRstOut), 16'h1);
    idle(PLEN - 1);
    check("R9 cpuRst still high", 16'(cpuRstOut), 16'h1);
    check("R11 boardRst quiet", 16'(boardRstOut), 16'h0);
    idle(1);
    check("R9 cpuRst ends", 16'(cpuRstOut), 16'h0);
  endtask

  task automatic testBoardRst();
    logic [15:0] d;
    int n;
    busWrite(6'h30, 16'h0001);
    align(n);
    busWrite(6'h24, sw(16'd2));
    waitBefore(n + 20);
    idle(1);
    check("R9 boardRst rises", 16'(boardRstOut), 16'h1);
    check("R11 cpuRst quiet", 16'(cpuRstOut), 16'h0);
    idle(PLEN - 1);
    check("R9 boardRst still high", 16'(boardRstOut), 16'h1);
    idle(1);
    check("R9 boardRst ends", 16'(boardRstOut), 16'h0);
    busRead(6'h18, d); check("R11 timer1 state kept", d, 16'h0002);
    busRead(6'h14, d); check("R11 timer1 limit kept", d, sw(16'd1));
  endtask

  task automatic testDecode();
    logic [15:0] d, s0, s1, s2, l0;
    busRead(6'h08, s0); busRead(6'h18, s1); busRead(6'h28, s2);
    busRead(6'h34, d);
    check("R10 summary", d, {13'b0, s2[1], s1[1], s0[1]});
    busWrite(6'h34, 16'h00FF);
    busRead(6'h34, d);
    check("R10 summary write ignored", d, {13'b0, s2[1], s1[1], s0[1]});
    busRead(6'h30, d); check("R10 mask not hit by 0x34 write", d, 16'h0001);
    busRead(6'h04, l0);
    busWrite(6'h0C, 16'hA5A5);
    busWrite(6'h08, 16'h0003);
    busRead(6'h04, d); check("R10 limit0 unchanged", d, l0);
    busRead(6'h18, d); check("R10 status write ignored", d, s1);
    busRead(6'h0C, d); check("R10 unmapped read", d, 16'h0000);
    busRead(6'h38, d); check("R10 unmapped pld read", d, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5 rstN = 1'b1;
    testReset();
    testIdleHold();
    testCountReload();
    testExpire();
    testIrq();
    testCpuRst();
    testBoardRst();
    testDecode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule